// File: doc/BRIEF.md
# GPIO Mismatch Remote Wakeup Controller

This block tracks the bus-suspend state of a peripheral device and raises a remote-wakeup request when a watched GPIO input moves away from its programmed level. From reset the device counts as suspended until configuration and enumeration are reported complete. After that it enters suspend on a suspend-detected pulse and leaves it on a resume or bus-reset pulse, or on a qualified pin mismatch.

Each pin whose mask bit is set is compared with its bit in the match-value word. The pins are first passed through a two-stage synchroniser. A mismatch on any masked pin that is present on two consecutive samples, while suspended and with remote wakeup enabled, ends suspend. It then drives the wakeup-signalling strobe for a window timed from a millisecond tick, nominally 12 ms. When the suspend-configuration option is set, a request to apply the suspend pin settings goes up one cycle before the suspend indicators and drops again as suspend is left.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: After reset, suspend_o is 1, rwu_sig_o is 0 and susp_cfg_apply_o is 0. The block stays in this state until cfg_done_i is seen high, and susp_det_i and resume_i have no effect before then.
- R2: suspend_no is always the bitwise complement of suspend_o.
- R3: When not suspended, a susp_det_i pulse with susp_cfg_en_i = 1 raises susp_cfg_apply_o on the next edge while suspend_o is still 0. suspend_o rises one edge later.
- R4: susp_cfg_apply_o stays high for the whole suspend and clears on the edge that leaves suspend. With susp_cfg_en_i = 0 at entry it stays 0.
- R5: While suspended, pin k triggers a wakeup only if wake_mask_i[k] = 1 and gpio_i[k] != wake_val_i[k]. Pins whose mask bit is 0 are ignored, and a mask of all zeros never wakes.
- R6: A mismatch lasting one clock cycle is ignored. A mismatch held for two consecutive cycles wakes.
- R7: With rwu_en_i = 0, a masked mismatch has no effect: suspend_o stays 1 and rwu_sig_o stays 0.
- R8: On a wakeup, suspend_o drops and rwu_sig_o stays high for HOLD_MS*CYC_PER_MS+1 cycles. This must fall between 10 ms and 15 ms of ticks. The block then returns to the active state.
- R9: A resume_i pulse while suspended returns the block to active with no signalling. A resume_i pulse during signalling ends it on the next edge.
- R10: A pin mismatch while not suspended produces no signalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | N_PINS | Raw GPIO pin levels |
| susp_det_i | input | 1 | Pulse: bus suspend detected |
| resume_i | input | 1 | Pulse: resume signalling or bus reset detected |
| cfg_done_i | input | 1 | Configuration and enumeration complete |
| rwu_en_i | input | 1 | Remote wakeup enabled by host |
| susp_cfg_en_i | input | 1 | Apply suspend pin settings while suspended |
| wake_mask_i | input | N_PINS | 1 = pin takes part in wakeup comparison |
| wake_val_i | input | N_PINS | Expected level of each watched pin |
| suspend_o | output | 1 | Suspend indicator, active high |
| suspend_no | output | 1 | Suspend indicator, active low |
| rwu_sig_o | output | 1 | Remote-wakeup signalling strobe |
| susp_cfg_apply_o | output | 1 | Request to switch pins to their suspend settings |

## Verification
The bench walks masked and unmasked pins, pins that match and pins that do not, and the enable bit. A design that inverted the comparison or ignored the mask would wake on the wrong vectors. It drives a one-cycle glitch, which a design without qualification would turn into a wakeup. It also measures the strobe length exactly, which catches an off-by-one tick count or a window outside 10 to 15 ms. Resume during signalling, mismatch while active, and inputs seen before enumeration completes are each driven, since a loose state machine would leak signalling or drop the suspend indicators early in those cases.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned WAKE_MIN_MS = 10;
  localparam int unsigned WAKE_MAX_MS = 15;

  typedef enum logic [2:0] {
    ST_UNCONF = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PREP   = 3'd2,
    ST_SUSP   = 3'd3,
    ST_WAKE   = 3'd4
  } wake_state_e;
endpackage

// File: rtl/gpio_wake_qual.sv
module gpio_wake_qual #(
  parameter int unsigned N_PINS    = 11,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] gpio_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic [N_PINS-1:0] val_i,
  output logic              hit_o
);
  logic [N_PINS-1:0] sync_q [SYNC_DEPTH];
  logic              miss;
  logic              miss_q;

  for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= gpio_i;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign miss = |((sync_q[SYNC_DEPTH-1] ^ val_i) & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miss_q <= 1'b0;
    else miss_q <= miss;
  end

  // two consecutive samples required
  assign hit_o = miss & miss_q;
endmodule

// File: rtl/gpio_wake_timer.sv
module gpio_wake_timer #(
  parameter int unsigned CYC_PER_MS = 48000,
  parameter int unsigned HOLD_MS    = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CYC_W = $clog2(CYC_PER_MS + 1);
  localparam int unsigned MS_W  = $clog2(HOLD_MS + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_END   = MS_W'(HOLD_MS);

  logic [CYC_W-1:0] cyc_q;
  logic [MS_W-1:0]  ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else if (cyc_q == CYC_LAST) begin
      cyc_q <= '0;
      if (ms_q != MS_END) ms_q <= ms_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign done_o = run_i && (ms_q == MS_END);
endmodule

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
  import gpio_wake_pkg::*;
#(
  parameter int unsigned N_PINS     = 11,
  parameter int unsigned CYC_PER_MS = 48000,
  parameter int unsigned HOLD_MS    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] gpio_i,
  input  logic              susp_det_i,
  input  logic              resume_i,
  input  logic              cfg_done_i,
  input  logic              rwu_en_i,
  input  logic              susp_cfg_en_i,
  input  logic [N_PINS-1:0] wake_mask_i,
  input  logic [N_PINS-1:0] wake_val_i,
  output logic              suspend_o,
  output logic              suspend_no,
  output logic              rwu_sig_o,
  output logic              susp_cfg_apply_o
);
  wake_state_e state_q, state_d;
  logic        apply_q;
  logic        pin_hit;
  logic        hold_done;

  gpio_wake_qual #(.N_PINS(N_PINS), .SYNC_DEPTH(2)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gpio_i (gpio_i),
    .mask_i (wake_mask_i),
    .val_i  (wake_val_i),
    .hit_o  (pin_hit)
  );

  gpio_wake_timer #(.CYC_PER_MS(CYC_PER_MS), .HOLD_MS(HOLD_MS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_WAKE),
    .done_o (hold_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNCONF: if (cfg_done_i) state_d = ST_ACTIVE;
      ST_ACTIVE: if (susp_det_i) state_d = ST_PREP;
      ST_PREP:   state_d = ST_SUSP;
      ST_SUSP: begin
        if (resume_i) state_d = ST_ACTIVE;
        else if (pin_hit && rwu_en_i) state_d = ST_WAKE;
      end
      ST_WAKE:   if (resume_i || hold_done) state_d = ST_ACTIVE;
      default:   state_d = ST_UNCONF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNCONF;
      apply_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ACTIVE && state_d == ST_PREP) apply_q <= susp_cfg_en_i;
      else if (state_d != ST_PREP && state_d != ST_SUSP) apply_q <= 1'b0;
    end
  end

  assign suspend_o        = (state_q == ST_UNCONF) || (state_q == ST_SUSP);
  assign suspend_no       = ~suspend_o;
  assign rwu_sig_o        = (state_q == ST_WAKE);
  assign susp_cfg_apply_o = apply_q;
endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk
  import gpio_wake_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 48000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic resume_i,
  input logic rwu_en_i,
  input logic suspend_o,
  input logic suspend_no,
  input logic rwu_sig_o,
  input logic susp_cfg_apply_o
);
  localparam int unsigned MIN_CYC = WAKE_MIN_MS * CYC_PER_MS;
  localparam int unsigned MAX_CYC = WAKE_MAX_MS * CYC_PER_MS + 1;

  int unsigned hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_cnt <= 0;
    else if (rwu_sig_o) hold_cnt <= hold_cnt + 1;
    else hold_cnt <= 0;
  end

  AST_SUSP_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni) suspend_no == !suspend_o); // R2
  AST_APPLY_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(susp_cfg_apply_o) |-> !suspend_o ##1 suspend_o); // R3
  AST_APPLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(suspend_o) |-> !susp_cfg_apply_o); // R4
  AST_WAKE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rwu_sig_o) |-> $past(rwu_en_i)); // R7
  AST_WAKE_FROM_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rwu_sig_o) |-> $past(suspend_o)); // R10
  AST_WAKE_NOT_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni) rwu_sig_o |-> !suspend_o); // R8
  AST_HOLD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni) hold_cnt <= MAX_CYC); // R8
  AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni) ($fell(rwu_sig_o) && !$past(resume_i)) |-> hold_cnt >= MIN_CYC); // R8
endmodule

bind gpio_wake_ctrl gpio_wake_chk #(.CYC_PER_MS(CYC_PER_MS)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .resume_i         (resume_i),
  .rwu_en_i         (rwu_en_i),
  .suspend_o        (suspend_o),
  .suspend_no       (suspend_no),
  .rwu_sig_o        (rwu_sig_o),
  .susp_cfg_apply_o (susp_cfg_apply_o)
);

// File: tb/sim_gpio_wake_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_wake_ctrl;
  localparam int unsigned NP  = 11;
  localparam int unsigned CYC = 4;
  localparam int unsigned HLD = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] gpio = '0;
  logic          susp_det = 1'b0, resume = 1'b0, cfg_done = 1'b0;
  logic          rwu_en = 1'b1, cfg_en = 1'b0;
  logic [NP-1:0] mask = '0, val = '0;
  logic          susp, susp_n, rwu, apply;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_wake_ctrl #(.N_PINS(NP), .CYC_PER_MS(CYC), .HOLD_MS(HLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .susp_det_i(susp_det),
    .resume_i(resume), .cfg_done_i(cfg_done), .rwu_en_i(rwu_en),
    .susp_cfg_en_i(cfg_en), .wake_mask_i(mask), .wake_val_i(val),
    .suspend_o(susp), .suspend_no(susp_n), .rwu_sig_o(rwu),
    .susp_cfg_apply_o(apply)
  );

  // {mask, value, gpio, rwu_en, expect_wake}
  localparam logic [34:0] VEC [8] = '{
    {11'h000, 11'h000, 11'h7FF, 1'b1, 1'b0},
    {11'h001, 11'h000, 11'h001, 1'b1, 1'b1},
    {11'h400, 11'h400, 11'h000, 1'b1, 1'b1},
    {11'h0F0, 11'h0A0, 11'h0AF, 1'b1, 1'b0},
    {11'h7FF, 11'h555, 11'h555, 1'b1, 1'b0},
    {11'h7FF, 11'h555, 11'h554, 1'b0, 1'b0},
    {11'h7FF, 11'h555, 11'h455, 1'b1, 1'b1},
    {11'h020, 11'h000, 11'h7DF, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_susp();
    susp_det = 1'b1; step(1); susp_det = 1'b0;
  endtask

  task automatic pulse_resume();
    resume = 1'b1; step(1); resume = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk(susp == 1'b1 && rwu == 1'b0 && apply == 1'b0, "R1", {susp, rwu, apply}, 3'b100);
    chk(susp_n == ~susp, "R2", susp_n, ~susp);
    pulse_resume();
    chk(susp == 1'b1, "R1 resume ignored before cfg", susp, 1);
    cfg_en = 1'b1;
    pulse_susp();
    chk(susp == 1'b1 && apply == 1'b0, "R1 susp_det ignored before cfg", {susp, apply}, 2'b10);
    cfg_en = 1'b0;
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;
    chk(susp == 1'b0 && susp_n == 1'b1, "R1 R2 leave after cfg", {susp, susp_n}, 2'b01);

    // table walk: R5 R7
    for (int i = 0; i < 8; i++) begin
      mask = VEC[i][34:24]; val = VEC[i][23:13]; rwu_en = VEC[i][1];
      gpio = val;
      step(3);
      pulse_susp();
      step(1);
      chk(susp == 1'b1, "R5 suspended", susp, 1);
      gpio = VEC[i][12:2];
      step(8);
      chk(rwu == VEC[i][0], (VEC[i][1] ? "R5 wake vector" : "R7 disabled"), rwu, VEC[i][0]);
      chk(susp == !VEC[i][0], "R5 suspend level", susp, !VEC[i][0]);
      chk(susp_n == ~susp, "R2", susp_n, ~susp);
      pulse_resume();
      chk(rwu == 1'b0 && susp == 1'b0, "R9 resume", {rwu, susp}, 0);
      gpio = val;
      step(3);
    end
    rwu_en = 1'b1;

    // R3 R4 apply sequencing
    mask = '0; val = '0; gpio = '0; cfg_en = 1'b1;
    pulse_susp();
    chk(apply == 1'b1 && susp == 1'b0, "R3 apply before suspend", {apply, susp}, 2'b10);
    step(1);
    chk(apply == 1'b1 && susp == 1'b1, "R3 suspend follows", {apply, susp}, 2'b11);
    cfg_en = 1'b0;
    step(5);
    chk(apply == 1'b1, "R4 apply held", apply, 1);
    pulse_resume();
    chk(apply == 1'b0 && susp == 1'b0 && rwu == 1'b0, "R4 R9 restore", {apply, susp, rwu}, 0);
    pulse_susp();
    step(1);
    chk(apply == 1'b0 && susp == 1'b1, "R4 option off", {apply, susp}, 2'b01);
    pulse_resume();

    // R6 glitch versus two-cycle mismatch
    mask = 11'h001; val = '0; gpio = '0;
    step(2);
    pulse_susp(); step(1);
    gpio = 11'h001; step(1); gpio = '0;
    step(8);
    chk(rwu == 1'b0 && susp == 1'b1, "R6 glitch ignored", {rwu, susp}, 2'b01);
    gpio = 11'h001; step(2); gpio = '0;
    step(4);
    chk(rwu == 1'b1, "R6 two samples wake", rwu, 1);
    pulse_resume();
    step(2);

    // R8 exact signalling length
    begin
      int hi_cyc = 0;
      int susp_bad = 0;
      pulse_susp(); step(1);
      gpio = 11'h001;
      for (int k = 0; k < 120; k++) begin
        step(1);
        if (rwu) begin
          hi_cyc++;
          if (susp) susp_bad++;
        end else if (hi_cyc > 0) break;
      end
      chk(hi_cyc == HLD * CYC + 1, "R8 length", hi_cyc, HLD * CYC + 1);
      chk(hi_cyc >= 10 * CYC && hi_cyc <= 15 * CYC + 1, "R8 window", hi_cyc, HLD * CYC + 1);
      chk(susp_bad == 0, "R8 suspend low while signalling", susp_bad, 0);
      chk(susp == 1'b0, "R8 active after", susp, 0);
    end

    // R10 mismatch while active
    step(10);
    chk(rwu == 1'b0 && susp == 1'b0, "R10 no wake while active", {rwu, susp}, 0);
    gpio = '0;
    step(3);

    // R9 resume cuts signalling
    pulse_susp(); step(1);
    gpio = 11'h001;
    step(6);
    chk(rwu == 1'b1, "R9 signalling started", rwu, 1);
    pulse_resume();
    chk(rwu == 1'b0 && susp == 1'b0, "R9 resume ends signalling", {rwu, susp}, 0);
    chk(susp_n == ~susp, "R2", susp_n, ~susp);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule